// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading four levels of translation tables from memory. A walk starts from a root table register. Each level uses a 9-bit slice of the virtual address as an index into the current table. The walk ends at the last level, which maps a 4 KB frame, or earlier at the third level when that entry marks a 2 MB page. The result is either a physical address, together with the leaf entry's write-through and cache-disable bits, or a fault code and the level at which the walk stopped.

A client presents one request at a time: the virtual address, a write flag, a user flag and an instruction-fetch flag. The block has a single memory port. It issues table reads through that port and, whenever an entry's accessed flag is clear, writes the same entry back with the flag set. Access rights are collected across all levels. Execute-disable is honoured only while the no-execute enable input is high.

Fault codes on `rsp_code`: 0 = none, 1 = non-canonical address, 2 = entry not present, 3 = reserved bit set, 4 = protection violation. Levels on `rsp_level`: 0 = top table (VA bits 47:39), 1 = second (38:30), 2 = directory (29:21), 3 = last table (20:12).

Top module: `ptw_walker`

## Requirements
- R1: The top table sits at `root_base` with its low 12 bits forced to zero. Every entry is read from the table base plus the level's 9-bit index times 8, and the base of the next table is taken from entry bits 39:12.
- R2: If VA bits 63:48 do not all equal bit 47, the walk reports code 1 at level 0 and makes no memory request. A canonical address whose upper bits are all ones translates normally.
- R3: An entry with bit 0 (present) clear stops the walk. The response gives code 2 and the level of that entry.
- R4: An entry with any of bits 51:40 nonzero stops the walk. The response gives code 3 and the level of that entry.
- R5: Bit 63 is the execute-disable flag. When `nx_en`=1 and the flag is set at any level, an instruction fetch gets code 4 and other accesses are allowed. When `nx_en`=0, bit 63 set counts as a reserved bit and gives code 3.
- R6: Bit 7 set in a level-2 entry ends the walk there. The physical address is then entry bits 39:21 joined with VA bits 20:0. Bit 7 has no effect at the other levels.
- R7: A write is refused unless bit 1 (writable) is set at every level walked. A user access is refused unless bit 2 (user) is set at every level walked. A refused access reports code 4 at the leaf level.
- R8: An entry whose bit 5 (accessed) is clear is written back to the address it was read from, with bit 5 set, before the walk goes on. An entry with bit 5 set is never written.
- R9: At most one memory request is in flight. Once a request is raised, its address, data and write flag stay unchanged until `mem_req_ready` is seen.
- R10: On success, `rsp_pa` is the frame base from the leaf entry joined with the page offset. `rsp_pwt` and `rsp_pcd` copy bits 3 and 4 of the leaf entry, `rsp_fault` is 0, and `rsp_valid` is high for exactly one cycle.
- R11: `req_ready` is high only while the walker is idle, and after reset the walker is idle with no response and no memory request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| req_fetch | input | 1 | Access is an instruction fetch |
| root_base | input | PA_W | Root table address, low 12 bits ignored |
| nx_en | input | 1 | Enables the execute-disable bit |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 3 | Fault code |
| rsp_level | output | 2 | Level where the walk ended |
| rsp_pa | output | PA_W | Physical address on success |
| rsp_pwt | output | 1 | Write-through from leaf |
| rsp_pcd | output | 1 | Cache-disable from leaf |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PA_W | Entry address |
| mem_wdata | output | 64 | Write-back entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read entry |

## Verification
The bench builds the walker with its default parameters: a 40-bit physical address, four levels of 9-bit indices and a 4 KB page offset. The 2 MB leaf therefore lands at level 2, and reserved bits 51:40 sit above the frame field. This lets a small sparse memory hold complete table trees, so every level can be made to end the walk by a missing entry, a reserved bit, a large page or a missing right. A mode in which the memory's ready signal alternates exercises request holding and back-pressure on both reads and write-backs.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_NONCANON = 3'd1,
    FLT_NOTPRES  = 3'd2,
    FLT_RSVD     = 3'd3,
    FLT_PROT     = 3'd4
  } flt_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_EVAL,
    S_WR_REQ,
    S_DONE
  } walk_st_e;

  localparam int unsigned ENT_W   = 64;
  localparam int unsigned BIT_P   = 0;
  localparam int unsigned BIT_W   = 1;
  localparam int unsigned BIT_U   = 2;
  localparam int unsigned BIT_PWT = 3;
  localparam int unsigned BIT_PCD = 4;
  localparam int unsigned BIT_A   = 5;
  localparam int unsigned BIT_PS  = 7;
  localparam int unsigned BIT_XD  = 63;
  localparam int unsigned RSV_HI  = 51;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned LVLS  = 4,
  localparam int unsigned LVL_W = $clog2(LVLS)
) (
  input  logic [63:0]      va,
  input  logic [LVL_W-1:0] lvl,
  output logic             canon,
  output logic [IDX_W-1:0] idx
);
  localparam int unsigned VA_W = OFF_W + IDX_W * LVLS;

  logic [63-VA_W+1:0]  top_bits;
  logic [IDX_W-1:0]    idx_arr [LVLS];

  assign top_bits = va[63:VA_W-1];
  assign canon    = (&top_bits) | ~(|top_bits);

  for (genvar l = 0; l < LVLS; l++) begin : g_field
    assign idx_arr[l] = va[OFF_W + IDX_W * (LVLS - l) - 1 -: IDX_W];
  end

  assign idx = idx_arr[lvl];
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W  = 40,
  parameter int unsigned OFF_W = 12
) (
  input  logic [ENT_W-1:0]      ent,
  input  logic                  nx_en,
  output logic                  present,
  output logic                  rsvd,
  output logic                  wr_ok,
  output logic                  us_ok,
  output logic                  xd,
  output logic                  acc,
  output logic                  ps,
  output logic                  pwt,
  output logic                  pcd,
  output logic [PA_W-OFF_W-1:0] nxt_base
);
  logic unused_bits;

  assign present  = ent[BIT_P];
  assign wr_ok    = ent[BIT_W];
  assign us_ok    = ent[BIT_U];
  assign pwt      = ent[BIT_PWT];
  assign pcd      = ent[BIT_PCD];
  assign acc      = ent[BIT_A];
  assign ps       = ent[BIT_PS];
  assign xd       = ent[BIT_XD] & nx_en;
  assign rsvd     = (|ent[RSV_HI:PA_W]) | (ent[BIT_XD] & ~nx_en);
  assign nxt_base = ent[PA_W-1:OFF_W];

  assign unused_bits = ^{ent[62:RSV_HI+1], ent[OFF_W-1:8], ent[6]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W  = 40,
  parameter int unsigned IDX_W = 9,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned LVLS  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_va,
  input  logic            req_write,
  input  logic            req_user,
  input  logic            req_fetch,
  input  logic [PA_W-1:0] root_base,
  input  logic            nx_en,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [2:0]      rsp_code,
  output logic [1:0]      rsp_level,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_pwt,
  output logic            rsp_pcd,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [63:0]     mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rdata
);
  localparam int unsigned LVL_W    = $clog2(LVLS);
  localparam int unsigned BASE_W   = PA_W - OFF_W;
  localparam int unsigned BIG_OFF  = OFF_W + IDX_W;
  localparam logic [LVL_W-1:0] DIR_LVL  = LVL_W'(LVLS - 2);
  localparam logic [LVL_W-1:0] LEAF_LVL = LVL_W'(LVLS - 1);

  walk_st_e          st_q, st_n;
  logic [63:0]       va_q, va_n;
  logic              wr_q, wr_n, usr_q, usr_n, fch_q, fch_n;
  logic [LVL_W-1:0]  lvl_q, lvl_n;
  logic [BASE_W-1:0] base_q, base_n;
  logic [63:0]       ent_q, ent_n;
  logic              aw_q, aw_n, au_q, au_n, ax_q, ax_n;
  flt_e              code_q, code_n;
  logic [PA_W-1:0]   pa_q, pa_n;
  logic              pwt_q, pwt_n, pcd_q, pcd_n;

  logic [63:0]       va_sel;
  logic              canon;
  logic [IDX_W-1:0]  idx;
  logic              e_pres, e_rsvd, e_wr, e_us, e_xd, e_acc, e_ps, e_pwt, e_pcd;
  logic [BASE_W-1:0] e_base;
  logic              w_all, u_all, x_any, big, leaf, prot, do_adv;
  logic [PA_W-1:0]   pa_leaf;

  assign va_sel = (st_q == S_IDLE) ? req_va : va_q;

  ptw_va_split #(.IDX_W(IDX_W), .OFF_W(OFF_W), .LVLS(LVLS)) u_split (
    .va(va_sel), .lvl(lvl_q), .canon(canon), .idx(idx)
  );

  ptw_entry_chk #(.PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .ent(ent_q), .nx_en(nx_en), .present(e_pres), .rsvd(e_rsvd),
    .wr_ok(e_wr), .us_ok(e_us), .xd(e_xd), .acc(e_acc), .ps(e_ps),
    .pwt(e_pwt), .pcd(e_pcd), .nxt_base(e_base)
  );

  // Rights collected over all levels walked so far, including this entry.
  assign w_all = aw_q & e_wr;
  assign u_all = au_q & e_us;
  assign x_any = ax_q | e_xd;
  assign big   = (lvl_q == DIR_LVL) & e_ps;
  assign leaf  = (lvl_q == LEAF_LVL) | big;
  assign prot  = (wr_q & ~w_all) | (usr_q & ~u_all) | (fch_q & x_any);
  assign pa_leaf = big ? {ent_q[PA_W-1:BIG_OFF], va_q[BIG_OFF-1:0]}
                       : {ent_q[PA_W-1:OFF_W], va_q[OFF_W-1:0]};

  assign mem_addr  = {base_q, {OFF_W{1'b0}}} + (PA_W'(idx) << 3);
  assign mem_wdata = ent_q | (64'd1 << BIT_A);

  always_comb begin
    st_n = st_q;   va_n = va_q;   wr_n = wr_q;   usr_n = usr_q;  fch_n = fch_q;
    lvl_n = lvl_q; base_n = base_q; ent_n = ent_q;
    aw_n = aw_q;   au_n = au_q;   ax_n = ax_q;   code_n = code_q;
    pa_n = pa_q;   pwt_n = pwt_q; pcd_n = pcd_q;
    mem_req_valid = 1'b0;
    mem_we        = 1'b0;
    do_adv        = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        va_n   = req_va;
        wr_n   = req_write;
        usr_n  = req_user;
        fch_n  = req_fetch;
        lvl_n  = '0;
        base_n = root_base[PA_W-1:OFF_W];
        aw_n   = 1'b1;
        au_n   = 1'b1;
        ax_n   = 1'b0;
        pa_n   = '0;
        pwt_n  = 1'b0;
        pcd_n  = 1'b0;
        if (!canon) begin
          code_n = FLT_NONCANON;
          st_n   = S_DONE;
        end else begin
          code_n = FLT_NONE;
          st_n   = S_RD_REQ;
        end
      end
      S_RD_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_n = S_RD_WAIT;
      end
      S_RD_WAIT: if (mem_rsp_valid) begin
        ent_n = mem_rdata;
        st_n  = S_EVAL;
      end
      S_EVAL: begin
        if (!e_pres) begin
          code_n = FLT_NOTPRES;
          st_n   = S_DONE;
        end else if (e_rsvd) begin
          code_n = FLT_RSVD;
          st_n   = S_DONE;
        end else begin
          aw_n = w_all;
          au_n = u_all;
          ax_n = x_any;
          if (!e_acc) st_n = S_WR_REQ;
          else        do_adv = 1'b1;
        end
      end
      S_WR_REQ: begin
        mem_req_valid = 1'b1;
        mem_we        = 1'b1;
        if (mem_req_ready) do_adv = 1'b1;
      end
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase

    if (do_adv) begin
      if (leaf) begin
        st_n = S_DONE;
        if (prot) begin
          code_n = FLT_PROT;
        end else begin
          code_n = FLT_NONE;
          pa_n   = pa_leaf;
          pwt_n  = e_pwt;
          pcd_n  = e_pcd;
        end
      end else begin
        lvl_n  = lvl_q + LVL_W'(1);
        base_n = e_base;
        st_n   = S_RD_REQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;   va_q <= '0;   wr_q <= 1'b0; usr_q <= 1'b0; fch_q <= 1'b0;
      lvl_q <= '0;      base_q <= '0; ent_q <= '0;
      aw_q <= 1'b0;     au_q <= 1'b0; ax_q <= 1'b0; code_q <= FLT_NONE;
      pa_q <= '0;       pwt_q <= 1'b0; pcd_q <= 1'b0;
    end else begin
      st_q <= st_n;     va_q <= va_n; wr_q <= wr_n; usr_q <= usr_n; fch_q <= fch_n;
      lvl_q <= lvl_n;   base_q <= base_n; ent_q <= ent_n;
      aw_q <= aw_n;     au_q <= au_n; ax_q <= ax_n; code_q <= code_n;
      pa_q <= pa_n;     pwt_q <= pwt_n; pcd_q <= pcd_n;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_DONE);
  assign rsp_code  = code_q;
  assign rsp_fault = (code_q != FLT_NONE);
  assign rsp_level = 2'(lvl_q);
  assign rsp_pa    = pa_q;
  assign rsp_pwt   = pwt_q;
  assign rsp_pcd   = pcd_q;

  // R9: a stalled request keeps its address and kind until accepted.
  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we))
    else $error("request changed while stalled");

  // R9: read data never arrives while a new request is raised.
  assert_one_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid)
    else $error("second request while read pending");

  // R8: each write-back follows the read of that entry by two cycles.
  assert_wb_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid && mem_we) |-> $past(mem_rsp_valid, 2))
    else $error("write-back without preceding read");

  // R2: a non-canonical result comes straight from acceptance.
  assert_canon_nomem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == FLT_NONCANON |-> $past(req_valid && req_ready))
    else $error("non-canonical fault after memory activity");

  // R10: result is a one-cycle pulse.
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("response longer than one cycle");

  // R11: idle means nothing else is going on.
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid)
    else $error("activity while idle");
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  localparam int PA_W = 40;
  localparam logic [39:0] ROOT = 40'h00_0000_1ABC;
  localparam logic [39:0] FRM  = 40'h05_6789_A000;
  localparam logic [39:0] LG   = 40'h12_3460_0000;
  localparam logic [63:0] VA_A = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] VA_N = 64'hFFFF_8765_4321_0FED;
  localparam logic [63:0] F_P = 64'h1, F_W = 64'h2, F_U = 64'h4, F_PWT = 64'h8,
                          F_PCD = 64'h10, F_A = 64'h20, F_PS = 64'h80;
  localparam logic [63:0] FULL = 64'h27;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic req_valid, req_ready, req_write, req_user, req_fetch, nx_en;
  logic [63:0] req_va;
  logic [PA_W-1:0] root_base;
  logic rsp_valid, rsp_fault, rsp_pwt, rsp_pcd;
  logic [2:0] rsp_code;
  logic [1:0] rsp_level;
  logic [PA_W-1:0] rsp_pa;
  logic mem_req_valid, mem_req_ready, mem_we, mem_rsp_valid;
  logic [PA_W-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  ptw_walker #(.PA_W(PA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
    .root_base(root_base), .nx_en(nx_en), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_level(rsp_level), .rsp_pa(rsp_pa), .rsp_pwt(rsp_pwt),
    .rsp_pcd(rsp_pcd), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  logic [63:0] mem [logic [39:0]];
  int n_rd, n_wr, n_chk, n_bad, hs_err;
  logic stall;
  logic prev_stall_req;
  logic [39:0] prev_addr;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        n_wr++;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
        n_rd++;
      end
    end
    if (rst_n && prev_stall_req && !(mem_req_valid && mem_addr == prev_addr)) hs_err++;
    prev_stall_req <= mem_req_valid && !mem_req_ready;
    prev_addr      <= mem_addr;
  end

  always @(negedge clk) mem_req_ready <= stall ? ~mem_req_ready : 1'b1;

  function automatic logic [39:0] tbl(input int l);
    return 40'h1000 * (l + 1);
  endfunction
  function automatic logic [39:0] ea(input int l, input logic [63:0] va);
    logic [8:0] ix;
    ix = va[47 - 9 * l -: 9];
    return tbl(l) + {28'd0, ix, 3'b000};
  endfunction
  function automatic logic [63:0] mk(input logic [39:0] b, input logic [63:0] fl);
    return {24'd0, b[39:12], 12'd0} | fl;
  endfunction

  task automatic build(input logic [63:0] va, input logic [63:0] leaf_fl);
    mem.delete();
    for (int l = 0; l < 3; l++) mem[ea(l, va)] = mk(tbl(l + 1), FULL);
    mem[ea(3, va)] = mk(FRM, leaf_fl);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  logic [2:0] o_code;
  logic [1:0] o_lvl;
  logic [39:0] o_pa;
  logic o_pwt, o_pcd, o_fault;

  task automatic walk(input logic [63:0] va, input logic w, input logic u, input logic f);
    int t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_rd = 0; n_wr = 0;
    req_va = va; req_write = w; req_user = u; req_fetch = f; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 300) begin @(negedge clk); t++; end
    if (!rsp_valid) begin
      n_chk++; n_bad++;
      $display("FAIL R10 no response act=0 exp=1");
    end
    o_code = rsp_code; o_lvl = rsp_level; o_pa = rsp_pa;
    o_pwt = rsp_pwt; o_pcd = rsp_pcd; o_fault = rsp_fault;
    @(negedge clk);
    chk("R10 pulse length", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R11 ready after reset", 64'(req_ready), 64'd1);
    chk("R11 no rsp after reset", 64'(rsp_valid), 64'd0);
    chk("R11 no mem req after reset", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_basic;
    build(VA_A, FULL | F_PWT | F_PCD);
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R10 code", 64'(o_code), 64'd0);
    chk("R10 fault", 64'(o_fault), 64'd0);
    chk("R1 R10 pa", 64'(o_pa), 64'({FRM[39:12], VA_A[11:0]}));
    chk("R10 pwt", 64'(o_pwt), 64'd1);
    chk("R10 pcd", 64'(o_pcd), 64'd1);
    chk("R1 reads", 64'(n_rd), 64'd4);
    chk("R8 no write when accessed", 64'(n_wr), 64'd0);
    build(VA_A, FULL);
    walk(VA_A, 1'b1, 1'b1, 1'b0);
    chk("R10 pwt clear", 64'(o_pwt), 64'd0);
    chk("R7 full rights write user", 64'(o_code), 64'd0);
  endtask

  task automatic t_canon;
    build(VA_N, FULL);
    walk(VA_N, 1'b0, 1'b0, 1'b0);
    chk("R2 negative canonical ok", 64'(o_code), 64'd0);
    chk("R2 negative pa", 64'(o_pa), 64'({FRM[39:12], VA_N[11:0]}));
    walk(64'h0000_8000_0000_1000, 1'b0, 1'b0, 1'b0);
    chk("R2 bit47 set upper clear", 64'(o_code), 64'd1);
    chk("R2 level", 64'(o_lvl), 64'd0);
    chk("R2 no memory", 64'(n_rd + n_wr), 64'd0);
    walk(64'h7FFF_0000_0000_0000, 1'b0, 1'b0, 1'b0);
    chk("R2 bit47 clear upper set", 64'(o_code), 64'd1);
    chk("R2 no memory 2", 64'(n_rd), 64'd0);
  endtask

  task automatic t_notpres;
    build(VA_A, FULL);
    mem[ea(2, VA_A)] = mem[ea(2, VA_A)] & ~F_P;
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R3 code", 64'(o_code), 64'd2);
    chk("R3 level", 64'(o_lvl), 64'd2);
    chk("R3 reads", 64'(n_rd), 64'd3);
    chk("R3 pa zero", 64'(o_pa), 64'd0);
    build(VA_A, FULL);
    mem[ea(0, VA_A)] = 64'd0;
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R3 top code", 64'(o_code), 64'd2);
    chk("R3 top level", 64'(o_lvl), 64'd0);
  endtask

  task automatic t_rsvd;
    build(VA_A, FULL);
    mem[ea(1, VA_A)] = mem[ea(1, VA_A)] | (64'd1 << 45);
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R4 code", 64'(o_code), 64'd3);
    chk("R4 level", 64'(o_lvl), 64'd1);
    chk("R4 reads", 64'(n_rd), 64'd2);
  endtask

  task automatic t_xd;
    build(VA_A, FULL | (64'd1 << 63));
    nx_en = 1'b1;
    walk(VA_A, 1'b0, 1'b0, 1'b1);
    chk("R5 fetch xd", 64'(o_code), 64'd4);
    chk("R5 fetch xd level", 64'(o_lvl), 64'd3);
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R5 data read xd", 64'(o_code), 64'd0);
    nx_en = 1'b0;
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R5 xd as reserved", 64'(o_code), 64'd3);
    nx_en = 1'b1;
  endtask

  task automatic t_large;
    build(VA_A, FULL);
    mem[ea(2, VA_A)] = mk(LG, FULL | F_PS | F_PCD);
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R6 code", 64'(o_code), 64'd0);
    chk("R6 pa", 64'(o_pa), 64'({LG[39:21], VA_A[20:0]}));
    chk("R6 reads", 64'(n_rd), 64'd3);
    chk("R6 leaf pcd", 64'(o_pcd), 64'd1);
    walk(VA_A, 1'b1, 1'b0, 1'b0);
    chk("R6 level", 64'(o_lvl), 64'd2);
    build(VA_A, FULL);
    mem[ea(0, VA_A)] = mem[ea(0, VA_A)] | F_PS;
    mem[ea(3, VA_A)] = mem[ea(3, VA_A)] | F_PS;
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R6 bit7 ignored reads", 64'(n_rd), 64'd4);
    chk("R6 bit7 ignored pa", 64'(o_pa), 64'({FRM[39:12], VA_A[11:0]}));
  endtask

  task automatic t_prot;
    build(VA_A, FULL);
    mem[ea(1, VA_A)] = mem[ea(1, VA_A)] & ~F_W;
    walk(VA_A, 1'b1, 1'b0, 1'b0);
    chk("R7 write ro", 64'(o_code), 64'd4);
    chk("R7 level", 64'(o_lvl), 64'd3);
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R7 read ro ok", 64'(o_code), 64'd0);
    build(VA_A, FULL);
    mem[ea(0, VA_A)] = mem[ea(0, VA_A)] & ~F_U;
    walk(VA_A, 1'b0, 1'b1, 1'b0);
    chk("R7 user denied", 64'(o_code), 64'd4);
    walk(VA_A, 1'b1, 1'b0, 1'b0);
    chk("R7 supervisor ok", 64'(o_code), 64'd0);
    build(VA_A, FULL);
    mem[ea(2, VA_A)] = mk(LG, F_P | F_U | F_A | F_PS);
    walk(VA_A, 1'b1, 1'b0, 1'b0);
    chk("R7 large write ro", 64'(o_code), 64'd4);
    chk("R7 large level", 64'(o_lvl), 64'd2);
  endtask

  task automatic t_accessed;
    mem.delete();
    for (int l = 0; l < 3; l++) mem[ea(l, VA_A)] = mk(tbl(l + 1), F_P | F_W | F_U);
    mem[ea(3, VA_A)] = mk(FRM, F_P | F_W | F_U);
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R8 code", 64'(o_code), 64'd0);
    chk("R8 writes", 64'(n_wr), 64'd4);
    for (int l = 0; l < 4; l++)
      chk("R8 entry marked", mem[ea(l, VA_A)],
          mk(l < 3 ? tbl(l + 1) : FRM, F_P | F_W | F_U | F_A));
    walk(VA_A, 1'b0, 1'b0, 1'b0);
    chk("R8 second walk no writes", 64'(n_wr), 64'd0);
  endtask

  task automatic t_stall;
    stall = 1'b1;
    mem.delete();
    for (int l = 0; l < 3; l++) mem[ea(l, VA_N)] = mk(tbl(l + 1), F_P | F_W | F_U);
    mem[ea(3, VA_N)] = mk(FRM, FULL);
    walk(VA_N, 1'b1, 1'b1, 1'b0);
    chk("R9 stalled code", 64'(o_code), 64'd0);
    chk("R9 stalled pa", 64'(o_pa), 64'({FRM[39:12], VA_N[11:0]}));
    chk("R9 stalled writes", 64'(n_wr), 64'd3);
    chk("R9 handshake holds", 64'(hs_err), 64'd0);
    stall = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; n_rd = 0; n_wr = 0; hs_err = 0;
    stall = 1'b0; mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rdata = '0;
    prev_stall_req = 1'b0; prev_addr = '0;
    req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_user = 1'b0; req_fetch = 1'b0;
    root_base = ROOT; nx_en = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_canon();
    t_notpres();
    t_rsvd();
    t_xd();
    t_large();
    t_prot();
    t_accessed();
    t_stall();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule